// File: doc/BRIEF.md
# Impedance Calibration Control Register

This block is the 32-bit control word for one output-impedance calibration slice of a memory interface. It holds a power-down request for the termination cell, a calibration start bit that clears itself, a bypass bit that makes the slice ignore chip-wide calibration requests, and an override bit.

When override is set, software supplies four 5-bit impedance codes directly from the register. When override is clear, the codes come from a 20-bit holding register. That holding register captures the result of an external calibration engine each time the engine finishes a run.

The engine is reached through a level request and a one-cycle done pulse that carries the 20-bit result. A global trigger input lets a chip-level controller start calibration in every slice that is not bypassed.

Top module: `zq_ctrl_reg`

## Requirements
- R1: After a synchronous active-low reset the register reads 0x0000014A. The codes show pull-down drive 10 and pull-up drive 10, with both termination codes 0. The calibration request, power-down and reject outputs are 0.
- R2: Bit 31 is stored on write, reads back, and drives `zq_pwrdn` from the cycle after the write.
- R3: A write with bit 30 = 1 and bit 28 = 0, made while no calibration runs, raises `cal_req` in the next cycle. Bit 30 then reads 1.
- R4: `cal_req` and read bit 30 stay 1 until a `cal_done` pulse arrives. In the cycle after that pulse both are 0.
- R5: On a `cal_done` pulse during a calibration, `cal_result` is captured. While bit 28 is 0, the four code outputs show the captured value. The captured value resets to the reset code fields.
- R6: While bit 28 is 1, the code outputs come from register bits 19:0, with pull-up termination in [19:15], pull-down termination in [14:10], pull-up drive in [9:5] and pull-down drive in [4:0].
- R7: Bits 27:20 always read 0, whatever was written to them.
- R8: A write with bits 30 and 28 both 1 starts nothing and leaves bit 30 at 0. `trig_reject` is 1 for exactly the next cycle.
- R9: A `glob_cal_trig` pulse starts calibration when the stored bit 29 is 0 and is ignored when it is 1. A local write of bit 30 still starts calibration while bit 29 is 1.
- R10: While a calibration runs, further local or global triggers are dropped, not queued. Writing 0 to bit 30 does not cancel the run.
- R11: A `cal_done` pulse while no calibration runs is ignored, and the captured codes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| glob_cal_trig | input | 1 | Chip-wide calibration trigger pulse |
| cal_req | output | 1 | Calibration request to the engine |
| cal_done | input | 1 | Engine completion pulse |
| cal_result | input | 20 | Engine result codes, valid with `cal_done` |
| zq_pwrdn | output | 1 | Power-down to the impedance cell |
| pu_term_code | output | 5 | Pull-up termination code |
| pd_term_code | output | 5 | Pull-down termination code |
| pu_drv_code | output | 5 | Pull-up drive code |
| pd_drv_code | output | 5 | Pull-down drive code |
| trig_reject | output | 1 | One-cycle flag for a rejected trigger write |

## Verification
The hardest case to reach from the ports is a trigger that arrives while a calibration is already running, and showing that nothing is queued once that run ends. The bench plays the engine itself and holds `cal_done` back, so the request stays high. During that window it fires a repeated local trigger, a global pulse and a write of 0 to bit 30. It then releases done and watches the request stay low for several cycles. An exhaustive sweep over all sixteen settings of the four control bits covers each trigger, override and bypass combination together with reject and capture.

// File: rtl/zqc_pkg.sv
// Package: shared field positions, widths and reset values of the
// impedance calibration control word.
// Assumes a single 32-bit register with four 5-bit code fields.
package zqc_pkg;
    localparam int ZQC_REG_W    = 32;
    localparam int ZQC_CODE_W   = 5;
    localparam int ZQC_N_CODES  = 4;
    localparam int ZQC_CODES_W  = ZQC_CODE_W * ZQC_N_CODES;
    localparam int ZQC_BIT_PD   = 31;
    localparam int ZQC_BIT_TRIG = 30;
    localparam int ZQC_BIT_BYP  = 29;
    localparam int ZQC_BIT_OVR  = 28;
    localparam logic [ZQC_CODES_W-1:0] ZQC_CODES_RST = 20'h0014A;

    typedef struct packed {
        logic pd;
        logic byp;
        logic ovr;
    } zqc_ctl_t;
endpackage

// File: rtl/zqc_field_regs.sv
// Module: storage for the plain read/write fields (power-down, bypass,
// override enable and the software code word).
// Assumes the caller has already removed reserved bits from the write data.
module zqc_field_regs
    import zqc_pkg::*;
#(
    parameter int                   CODES_W   = ZQC_CODES_W,
    parameter logic [CODES_W-1:0]   CODES_RST = ZQC_CODES_RST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  zqc_ctl_t           wr_ctl,
    input  logic [CODES_W-1:0] wr_codes,
    output zqc_ctl_t           ctl,
    output logic [CODES_W-1:0] sw_codes
);

    // Load control bits and software codes on each register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl      <= '0;
            sw_codes <= CODES_RST;
        end else if (wr_en) begin
            ctl      <= wr_ctl;
            sw_codes <= wr_codes;
        end
    end

endmodule

// File: rtl/zqc_cal_seq.sv
// Module: calibration sequencer. It accepts local or global triggers,
// holds the engine request until done, captures the engine result, and
// flags trigger writes made with override enabled.
// Assumes cal_done is a single-cycle pulse; done while idle is ignored.
module zqc_cal_seq
    import zqc_pkg::*;
#(
    parameter int                 CODES_W   = ZQC_CODES_W,
    parameter logic [CODES_W-1:0] CODES_RST = ZQC_CODES_RST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               local_trig,
    input  logic               local_ovr,
    input  logic               glob_trig,
    input  logic               byp,
    input  logic               cal_done,
    input  logic [CODES_W-1:0] cal_result,
    output logic               busy,
    output logic [CODES_W-1:0] hold_codes,
    output logic               trig_err
);

    logic local_ok;
    logic glob_ok;
    logic start;

    // Qualify the trigger sources; a running calibration blocks both.
    always_comb begin
        local_ok = local_trig & ~local_ovr;
        glob_ok  = glob_trig & ~byp;
        start    = ~busy & (local_ok | glob_ok);
    end

    // Request flag: set on an accepted trigger, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (start)
            busy <= 1'b1;
        else if (cal_done)
            busy <= 1'b0;
    end

    // Capture the engine result when a running calibration completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_codes <= CODES_RST;
        else if (busy && cal_done)
            hold_codes <= cal_result;
    end

    // One-cycle reject flag for a trigger written with override set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_err <= 1'b0;
        else
            trig_err <= local_trig & local_ovr;
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cal_done) |=> busy);

    assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cal_done) |=> !busy);

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cal_done) |=> (hold_codes == $past(cal_result)));

    assert_bypass_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && glob_trig && byp && !local_ok) |=> !busy);

    assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(local_trig || glob_trig));

endmodule

// File: rtl/zqc_code_mux.sv
// Module: per-code selection between software codes and captured
// calibration codes, one slice per code field.
// Assumes both inputs use the same field packing.
module zqc_code_mux
    import zqc_pkg::*;
#(
    parameter int CODE_W  = ZQC_CODE_W,
    parameter int N_CODES = ZQC_N_CODES,
    localparam int CODES_W = CODE_W * N_CODES
) (
    input  logic               ovr,
    input  logic [CODES_W-1:0] sw_codes,
    input  logic [CODES_W-1:0] hold_codes,
    output logic [CODES_W-1:0] codes
);

    for (genvar g = 0; g < N_CODES; g++) begin : g_slice
        // Select the source for one code field.
        always_comb begin
            codes[g*CODE_W +: CODE_W] = ovr ? sw_codes[g*CODE_W +: CODE_W]
                                            : hold_codes[g*CODE_W +: CODE_W];
        end
    end

endmodule

// File: rtl/zq_ctrl_reg.sv
// Module: top of the impedance calibration control register. It decodes
// writes into field storage and the sequencer, assembles the read word and
// drives the code outputs.
// Assumes a single-register bus with write strobe and always-valid read data.
module zq_ctrl_reg
    import zqc_pkg::*;
#(
    parameter int CODE_W  = ZQC_CODE_W,
    parameter int N_CODES = ZQC_N_CODES,
    parameter int REG_W   = ZQC_REG_W,
    localparam int CODES_W = CODE_W * N_CODES,
    localparam int RSV_W   = REG_W - 4 - CODES_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               glob_cal_trig,
    output logic               cal_req,
    input  logic               cal_done,
    input  logic [CODES_W-1:0] cal_result,
    output logic               zq_pwrdn,
    output logic [CODE_W-1:0]  pu_term_code,
    output logic [CODE_W-1:0]  pd_term_code,
    output logic [CODE_W-1:0]  pu_drv_code,
    output logic [CODE_W-1:0]  pd_drv_code,
    output logic               trig_reject
);

    localparam logic [CODES_W-1:0] CODES_RST = CODES_W'(ZQC_CODES_RST);

    zqc_ctl_t           wr_ctl;
    zqc_ctl_t           ctl;
    logic [CODES_W-1:0] sw_codes;
    logic [CODES_W-1:0] hold_codes;
    logic [CODES_W-1:0] codes;
    logic               busy;
    logic               local_trig;

    // Split the write word into control bits and the trigger strobe.
    always_comb begin
        wr_ctl.pd  = reg_wdata[REG_W-1];
        wr_ctl.byp = reg_wdata[REG_W-3];
        wr_ctl.ovr = reg_wdata[REG_W-4];
        local_trig = reg_wr_en & reg_wdata[REG_W-2];
    end

    zqc_field_regs #(.CODES_W(CODES_W), .CODES_RST(CODES_RST)) fields_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_ctl   (wr_ctl),
        .wr_codes (reg_wdata[CODES_W-1:0]),
        .ctl      (ctl),
        .sw_codes (sw_codes)
    );

    zqc_cal_seq #(.CODES_W(CODES_W), .CODES_RST(CODES_RST)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_trig (local_trig),
        .local_ovr  (wr_ctl.ovr),
        .glob_trig  (glob_cal_trig),
        .byp        (ctl.byp),
        .cal_done   (cal_done),
        .cal_result (cal_result),
        .busy       (busy),
        .hold_codes (hold_codes),
        .trig_err   (trig_reject)
    );

    zqc_code_mux #(.CODE_W(CODE_W), .N_CODES(N_CODES)) mux_i (
        .ovr        (ctl.ovr),
        .sw_codes   (sw_codes),
        .hold_codes (hold_codes),
        .codes      (codes)
    );

    // Assemble read data and split the code word onto the output pins.
    always_comb begin
        reg_rdata    = {ctl.pd, busy, ctl.byp, ctl.ovr, {RSV_W{1'b0}}, sw_codes};
        cal_req      = busy;
        zq_pwrdn     = ctl.pd;
        pd_drv_code  = codes[0*CODE_W +: CODE_W];
        pu_drv_code  = codes[1*CODE_W +: CODE_W];
        pd_term_code = codes[2*CODE_W +: CODE_W];
        pu_term_code = codes[3*CODE_W +: CODE_W];
    end

    assert_ovr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ovr && !reg_wr_en) |=> $stable({pu_term_code, pd_term_code, pu_drv_code, pd_drv_code}));

    assert_pwrdn_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (zq_pwrdn == $past(reg_wdata[REG_W-1])));

endmodule

// File: tb/zq_ctrl_reg_tb.sv
module zq_ctrl_reg_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        glob_cal_trig = 1'b0;
    logic        cal_req;
    logic        cal_done = 1'b0;
    logic [19:0] cal_result = '0;
    logic        zq_pwrdn;
    logic [4:0]  pu_term_code, pd_term_code, pu_drv_code, pd_drv_code;
    logic        trig_reject;

    int n_checks = 0;
    int n_fail = 0;
    logic [19:0] exp_hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    zq_ctrl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .glob_cal_trig(glob_cal_trig), .cal_req(cal_req),
        .cal_done(cal_done), .cal_result(cal_result), .zq_pwrdn(zq_pwrdn),
        .pu_term_code(pu_term_code), .pd_term_code(pd_term_code),
        .pu_drv_code(pu_drv_code), .pd_drv_code(pd_drv_code),
        .trig_reject(trig_reject)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_codes(input string tag, input logic [19:0] exp);
        chk(tag, {12'h0, pu_term_code, pd_term_code, pu_drv_code, pd_drv_code}, {12'h0, exp});
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic done_pulse(input logic [19:0] r);
        cal_done = 1'b1;
        cal_result = r;
        tick();
        cal_done = 1'b0;
    endtask

    task automatic glob();
        glob_cal_trig = 1'b1;
        tick();
        glob_cal_trig = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        exp_hold = 20'h0014A;

        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'h0000014A);
        chk_codes("R1 codes", {5'd0, 5'd0, 5'd10, 5'd10});
        chk("R1 req/pd/err", {29'h0, cal_req, zq_pwrdn, trig_reject}, 32'h0);

        // R11 done while idle is ignored
        done_pulse(20'hFFFFF);
        chk_codes("R11 idle done", exp_hold);
        chk("R11 req", {31'h0, cal_req}, 32'h0);

        // R7 reserved bits read zero
        wr(32'h0FFFFFFF);
        chk("R7 rdata", reg_rdata, 32'h000FFFFF);
        chk_codes("R5 hold shown with override clear", exp_hold);

        // R6 override code sweep with field order
        for (int i = 0; i < 32; i++) begin
            logic [4:0] a, b, c, d;
            a = 5'(i); b = 5'(i*3+1); c = 5'(i*5+2); d = 5'(31-i);
            wr(32'h1FF00000 | {12'h0, a, b, c, d});
            chk("R6 pu_term", {27'h0, pu_term_code}, {27'h0, a});
            chk("R6 pd_term", {27'h0, pd_term_code}, {27'h0, b});
            chk("R6 pu_drv", {27'h0, pu_drv_code}, {27'h0, c});
            chk("R6 pd_drv", {27'h0, pd_drv_code}, {27'h0, d});
            chk("R7 rdata sweep", reg_rdata, {12'h100, a, b, c, d});
        end

        // Exhaustive sweep of the four control bits (R2 R3 R4 R5 R8 R9)
        for (int c = 0; c < 16; c++) begin
            logic [3:0]  cb;
            logic [19:0] sw, res;
            logic        acc;
            cb  = 4'(c);
            sw  = 20'(c * 20'h1357 + 20'h2468);
            res = 20'(c * 20'h0F0F1 + 20'h3);
            acc = cb[2] & ~cb[0];
            wr({cb, 8'hA5, sw});
            chk("R2/R3/R8 rdata", reg_rdata, {cb[3], acc, cb[1], cb[0], 8'h00, sw});
            chk("R3 req", {31'h0, cal_req}, {31'h0, acc});
            chk("R8 reject", {31'h0, trig_reject}, {31'h0, cb[2] & cb[0]});
            chk("R2 pwrdn", {31'h0, zq_pwrdn}, {31'h0, cb[3]});
            chk_codes("R6/R5 codes", cb[0] ? sw : exp_hold);
            tick();
            chk("R8 reject one cycle", {31'h0, trig_reject}, 32'h0);
            chk("R4 req held", {31'h0, cal_req}, {31'h0, acc});
            if (acc) begin
                done_pulse(res);
                exp_hold = res;
                chk("R4 req cleared", {31'h0, cal_req}, 32'h0);
                chk("R4 bit30 cleared", {31'h0, reg_rdata[30]}, 32'h0);
                chk_codes("R5 captured", exp_hold);
            end
        end

        // R10 triggers during a running calibration are dropped
        wr(32'h40000000);
        chk("R3 start", {31'h0, cal_req}, 32'h1);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R4 hold wait", {31'h0, cal_req}, 32'h1);
        end
        wr(32'h40000000);
        glob();
        wr(32'h00000000);
        chk("R10 no cancel", {31'h0, reg_rdata[30]}, 32'h1);
        done_pulse(20'hABCDE);
        exp_hold = 20'hABCDE;
        chk_codes("R5 after run", exp_hold);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R10 not queued", {31'h0, cal_req}, 32'h0);
        end

        // R9 global trigger and bypass
        glob();
        chk("R9 global start", {31'h0, cal_req}, 32'h1);
        done_pulse(20'h13579);
        exp_hold = 20'h13579;
        chk_codes("R9 global result", exp_hold);
        wr(32'h20000000);
        glob();
        chk("R9 bypass blocks global", {31'h0, cal_req}, 32'h0);
        chk("R9 bypass bit30", {31'h0, reg_rdata[30]}, 32'h0);
        wr(32'h60000000);
        chk("R9 local with bypass", {31'h0, cal_req}, 32'h1);
        done_pulse(20'h0F0F0);
        exp_hold = 20'h0F0F0;
        chk("R9 req drop", {31'h0, cal_req}, 32'h0);
        chk_codes("R9 local result", exp_hold);

        // R11 idle done again after activity
        done_pulse(20'h55555);
        chk_codes("R11 idle done later", exp_hold);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule